// File: doc/BRIEF.md
# Suspend-Aware Programmable Clock Output

This block derives an output clock from a 48 MHz reference. A 4-bit divisor N in a configuration word sets the output frequency to 48/(N+1) MHz, with a 50% duty cycle. The output uses half-cycle resolution: a registered high-phase value and a registered low-phase value are selected by the level of the reference clock. A new divisor takes effect only when the current output period has finished, so reprogramming never cuts a pulse short.

When the suspend request input stays high for a programmable number of reference cycles (96000 by default, roughly 2 ms), the block enters suspend. Two configuration bits then decide what happens. With the slow-clock disable bit clear, the output moves to a free-running slow clock of about 100 kHz. With it set, the output is parked low. With the clocks-always-running bit clear, the internal clock enable drops. Dropping the request, or a bus reset, ends suspend. The divided clock comes back at the next point where the divider and the slow clock are both low.

A bus reset leaves the configuration untouched. Only the asynchronous hardware reset restores the defaults.

Top module: `susp_clkout`

## Requirements
- R1: With divisor N (configuration bits 11:8), clk_out repeats every N+1 reference cycles. It is high for exactly N+1 reference half-cycles and low for exactly N+1 half-cycles.
- R2: After hardware reset, cfg_rdata reads 16'h2300 (divisor 3, always-running bit 12 = 0, slow-clock disable bit 13 = 1). clk_en reads 1 and suspended reads 0.
- R3: A write with cfg_wr high updates bits 13, 12 and 11:8. After the write edge, cfg_rdata returns those bits, and every other bit reads 0.
- R4: When the divisor changes while the output runs, every complete high and low run of clk_out lasts either the old N+1 or the new N+1 half-cycles.
- R5: suspended rises at the rising edge that is the SUSP_DELAY-th consecutive edge with susp_req high. Clearing susp_req before then cancels the count, and a new request needs the full count again.
- R6: While suspended with bit 13 = 0, clk_out is a slow clock whose high and low runs each last LAZY_HALF reference cycles.
- R7: While suspended with bit 13 = 1, clk_out stays low.
- R8: With bit 12 = 0, clk_en falls at the same edge where suspended rises. With bit 12 = 1, clk_en stays 1 through suspend.
- R9: After susp_req is cleared, suspended reads 0 and clk_en reads 1 at the next rising edge. The divided clock of R1 then resumes.
- R10: A bus_rst pulse leaves the configuration word unchanged. It clears suspended and restarts the suspend count.
- R11: The output changes source only at an edge where both the divided clock and the slow clock have been low. Across such a change, every complete high run lasts either N+1 half-cycles or 2*LAZY_HALF half-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | Bus reset pulse, synchronous |
| susp_req | input | 1 | Suspend request level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data |
| clk_out | output | 1 | Divided or slow output clock |
| clk_en | output | 1 | Internal clock enable |
| suspended | output | 1 | Suspend delay has expired |

## Verification
Two functions can fall into the same reference cycle: the suspend timer expiring and a divider period boundary. The source switch must then wait for a cycle in which both clocks are low. The bench provokes this by raising the request while the divider runs and capturing clk_out continuously across the expiry, at several divisor values. It then judges every complete high run against the two legal lengths. A divisor write that lands in the middle of a period is judged the same way, against the old and new run lengths.

// File: rtl/susp_clk_pkg.sv
package susp_clk_pkg;
    localparam int CFG_W    = 16;
    localparam int DIV_W    = 4;
    localparam int DIV_LSB  = 8;
    localparam int RUN_BIT  = 12;
    localparam int LAZY_BIT = 13;
    localparam int DEF_DIV  = 3;

    typedef enum logic [1:0] {
        SRC_DIV  = 2'd0,
        SRC_LAZY = 2'd1,
        SRC_OFF  = 2'd2
    } src_e;
endpackage

// File: rtl/sck_cfg_reg.sv
module sck_cfg_reg
    import susp_clk_pkg::*;
#(
    parameter int W      = CFG_W,
    parameter int DW     = DIV_W,
    parameter int DEFDIV = DEF_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    output logic [DW-1:0] div_o,
    output logic          run_o,
    output logic          lazy_off_o
);
    typedef struct packed {
        logic [DW-1:0] div;
        logic          run;
        logic          lazy_off;
    } cfg_t;

    cfg_t d, q;

    always_comb begin
        d = q;
        if (wr_i) begin
            d.div      = wdata_i[DIV_LSB +: DW];
            d.run      = wdata_i[RUN_BIT];
            d.lazy_off = wdata_i[LAZY_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.div      <= DW'(DEFDIV);
            q.run      <= 1'b0;
            q.lazy_off <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata_o                  = '0;
        rdata_o[DIV_LSB +: DW]   = q.div;
        rdata_o[RUN_BIT]         = q.run;
        rdata_o[LAZY_BIT]        = q.lazy_off;
    end

    assign div_o      = q.div;
    assign run_o      = q.run;
    assign lazy_off_o = q.lazy_off;

    assert_wr_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (rdata_o[DIV_LSB +: DW] == $past(wdata_i[DIV_LSB +: DW]))
                 && (rdata_o[LAZY_BIT] == $past(wdata_i[LAZY_BIT])));
endmodule

// File: rtl/sck_divider.sv
module sck_divider
    import susp_clk_pkg::*;
#(
    parameter int DW     = DIV_W,
    parameter int DEFDIV = DEF_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div_i,
    output logic          hi_d_o,
    output logic          lo_d_o,
    output logic          wrap_o
);
    localparam int HW = DW + 2;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] n;
    } div_t;

    div_t d, q;
    logic [HW-1:0] half_pos, half_len;

    always_comb begin
        d      = q;
        wrap_o = (q.cnt == q.n);
        if (wrap_o) begin
            d.cnt = '0;
            d.n   = div_i;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        half_pos = {1'b0, d.cnt, 1'b0};
        half_len = HW'(d.n) + HW'(1);
        hi_d_o   = (half_pos < half_len);
        lo_d_o   = ((half_pos + HW'(1)) < half_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= DW'(DEFDIV);
            q.n   <= DW'(DEFDIV);
        end else begin
            q <= d;
        end
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= q.n);

    assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> $stable(q.n));
endmodule

// File: rtl/sck_susp_timer.sv
module sck_susp_timer #(
    parameter int DELAY = 96000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic bus_rst_i,
    input  logic run_i,
    output logic susp_o,
    output logic en_o
);
    localparam int CW = $clog2(DELAY + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          susp;
        logic          en;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (bus_rst_i || !req_i) begin
            d.cnt  = '0;
            d.susp = 1'b0;
        end else if (!q.susp) begin
            if (q.cnt == CW'(DELAY - 1)) d.susp = 1'b1;
            else                         d.cnt  = q.cnt + 1'b1;
        end
        d.en = !(d.susp && !run_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.susp <= 1'b0;
            q.en   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign susp_o = q.susp;
    assign en_o   = q.en;

    assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i || bus_rst_i) |=> !susp_o);

    assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_o) |-> ($past(q.cnt) == CW'(DELAY - 1)));

    assert_clken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !susp_o |-> en_o);
endmodule

// File: rtl/sck_outsel.sv
module sck_outsel
    import susp_clk_pkg::*;
#(
    parameter int LAZY_HALF = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_hi_i,
    input  logic div_lo_i,
    input  logic div_wrap_i,
    input  logic susp_i,
    input  logic lazy_off_i,
    output logic hi_o,
    output logic lo_o
);
    localparam int LW = $clog2(LAZY_HALF + 1);

    typedef struct packed {
        logic [LW-1:0] lcnt;
        logic          lvl;
        src_e          src;
        logic          hi;
        logic          lo;
    } sel_t;

    sel_t d, q;
    src_e tgt;
    logic swap_ok;

    always_comb begin
        d = q;
        if (q.lcnt == LW'(LAZY_HALF - 1)) begin
            d.lcnt = '0;
            d.lvl  = !q.lvl;
        end else begin
            d.lcnt = q.lcnt + 1'b1;
        end

        if (!susp_i)         tgt = SRC_DIV;
        else if (lazy_off_i) tgt = SRC_OFF;
        else                 tgt = SRC_LAZY;

        swap_ok = div_wrap_i && !q.lvl && !d.lvl;
        if (swap_ok) d.src = tgt;

        unique case (d.src)
            SRC_DIV: begin
                d.hi = div_hi_i;
                d.lo = div_lo_i;
            end
            SRC_LAZY: begin
                d.hi = d.lvl;
                d.lo = d.lvl;
            end
            default: begin
                d.hi = 1'b0;
                d.lo = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lcnt <= '0;
            q.lvl  <= 1'b0;
            q.src  <= SRC_DIV;
            q.hi   <= 1'b0;
            q.lo   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hi_o = q.hi;
    assign lo_o = q.lo;

    assert_switch_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (d.src != q.src) |-> (!q.lo && !q.lvl));

    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.src == SRC_OFF) |-> (!q.hi && !q.lo));
endmodule

// File: rtl/susp_clkout.sv
module susp_clkout
    import susp_clk_pkg::*;
#(
    parameter int W          = CFG_W,
    parameter int DW         = DIV_W,
    parameter int DEFDIV     = DEF_DIV,
    parameter int SUSP_DELAY = 96000,
    parameter int LAZY_HALF  = 240
) (
    input  logic         ref_clk,
    input  logic         rst_n,
    input  logic         bus_rst,
    input  logic         susp_req,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_wdata,
    output logic [W-1:0] cfg_rdata,
    output logic         clk_out,
    output logic         clk_en,
    output logic         suspended
);
    logic [DW-1:0] div_n;
    logic          run_on, lazy_off;
    logic          dhi, dlo, dwrap;
    logic          ohi, olo;

    sck_cfg_reg #(.W(W), .DW(DW), .DEFDIV(DEFDIV)) u_cfg (
        .clk(ref_clk), .rst_n(rst_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata),
        .rdata_o(cfg_rdata), .div_o(div_n), .run_o(run_on), .lazy_off_o(lazy_off)
    );

    sck_divider #(.DW(DW), .DEFDIV(DEFDIV)) u_div (
        .clk(ref_clk), .rst_n(rst_n), .div_i(div_n),
        .hi_d_o(dhi), .lo_d_o(dlo), .wrap_o(dwrap)
    );

    sck_susp_timer #(.DELAY(SUSP_DELAY)) u_tmr (
        .clk(ref_clk), .rst_n(rst_n), .req_i(susp_req), .bus_rst_i(bus_rst),
        .run_i(run_on), .susp_o(suspended), .en_o(clk_en)
    );

    sck_outsel #(.LAZY_HALF(LAZY_HALF)) u_sel (
        .clk(ref_clk), .rst_n(rst_n), .div_hi_i(dhi), .div_lo_i(dlo),
        .div_wrap_i(dwrap), .susp_i(suspended), .lazy_off_i(lazy_off),
        .hi_o(ohi), .lo_o(olo)
    );

    always_comb clk_out = ref_clk ? ohi : olo;
endmodule

// File: tb/susp_clkout_test.sv
module susp_clkout_test;
    localparam int CLK_P = 20;
    localparam int DLY   = 40;
    localparam int LH    = 6;

    logic        ref_clk = 1'b0;
    logic        rst_n = 1'b0, bus_rst = 1'b0, susp_req = 1'b0, cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        clk_out, clk_en, suspended;

    int n_chk = 0, n_bad = 0;
    logic halves [0:1023];

    susp_clkout #(.SUSP_DELAY(DLY), .LAZY_HALF(LH)) uut (
        .ref_clk(ref_clk), .rst_n(rst_n), .bus_rst(bus_rst), .susp_req(susp_req),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .clk_out(clk_out), .clk_en(clk_en), .suspended(suspended)
    );

    always #(CLK_P/2) ref_clk = !ref_clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word(input bit lz, input bit run, input int n);
        word = {2'b00, lz, run, 4'(n), 8'h00};
    endfunction

    task automatic cfg_write(input logic [15:0] v);
        @(negedge ref_clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge ref_clk);
        cfg_wr = 1'b0;
    endtask

    task automatic capture(input int n);
        for (int i = 0; i < n; i += 2) begin
            @(posedge ref_clk); #(CLK_P/4); halves[i]   = clk_out;
            @(negedge ref_clk); #(CLK_P/4); halves[i+1] = clk_out;
        end
    endtask

    task automatic check_runs(input int n, input int ha, input int hb,
                              input int la, input int lb, input bit lo_any,
                              input string tag);
        int run = 1, idx = 0, inner = 0, bad_len = -1, bad_ref = 0;
        for (int i = 1; i <= n; i++) begin
            if (i < n && halves[i] == halves[i-1]) run++;
            else begin
                if (idx > 0 && i < n) begin
                    inner++;
                    if (halves[i-1]) begin
                        if (run != ha && run != hb && bad_len < 0) begin bad_len = run; bad_ref = ha; end
                    end else if (!lo_any && run != la && run != lb && bad_len < 0) begin
                        bad_len = run; bad_ref = la;
                    end
                end
                idx++;
                run = 1;
            end
        end
        if (inner < 2) check(1'b0, {tag, " too few runs"}, inner, 2);
        else check(bad_len < 0, tag, bad_len, bad_ref);
    endtask

    task automatic count_to_susp(output int n);
        n = 0;
        for (int k = 1; k <= DLY + 10; k++) begin
            @(posedge ref_clk); #1;
            if (suspended && n == 0) n = k;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        int hcount;
        repeat (3) @(negedge ref_clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        check(cfg_rdata == 16'h2300, "R2 reset cfg", cfg_rdata, 16'h2300);
        check(clk_en == 1'b1, "R2 reset clk_en", clk_en, 1);
        check(suspended == 1'b0, "R2 reset suspended", suspended, 0);
        repeat (20) @(negedge ref_clk);
        capture(2 * 4 * 6);
        check_runs(48, 4, 4, 4, 4, 1'b0, "R2 default divisor 3");

        // R1 and R3: full divisor sweep
        for (int n = 0; n < 16; n++) begin
            cfg_write(word(1'b1, n[0], n));
            check(cfg_rdata == word(1'b1, n[0], n), "R3 readback", cfg_rdata, word(1'b1, n[0], n));
            repeat (40) @(negedge ref_clk);
            capture(2 * (n + 1) * 6 + 4);
            check_runs(2 * (n + 1) * 6 + 4, n + 1, n + 1, n + 1, n + 1, 1'b0, "R1 sweep");
        end
        cfg_write(16'hFFFF);
        check(cfg_rdata == 16'h3F00, "R3 reserved bits zero", cfg_rdata, 16'h3F00);

        // R4: divisor changes mid-run
        for (int p = 0; p < 5; p++) begin
            int o, m;
            o = (p == 0) ? 15 : (p == 1) ? 0 : (p == 2) ? 3 : (p == 3) ? 7 : 1;
            m = (p == 0) ? 0 : (p == 1) ? 15 : (p == 2) ? 7 : (p == 3) ? 2 : 14;
            cfg_write(word(1'b1, 1'b0, o));
            repeat (40) @(negedge ref_clk);
            fork
                capture(400);
                begin repeat (37 + p) @(negedge ref_clk); cfg_write(word(1'b1, 1'b0, m)); end
            join
            check_runs(400, o + 1, m + 1, o + 1, m + 1, 1'b0, "R4 divisor change");
        end

        // R5, R8, R6: suspend to slow clock
        cfg_write(word(1'b0, 1'b0, 2));
        repeat (20) @(negedge ref_clk);
        susp_req = 1'b1;
        count_to_susp(cnt);
        check(cnt == DLY, "R5 delay length", cnt, DLY);
        check(clk_en == 1'b0, "R8 clk_en off", clk_en, 0);
        repeat (20) @(negedge ref_clk);
        capture(120);
        check_runs(120, 2 * LH, 2 * LH, 2 * LH, 2 * LH, 1'b0, "R6 slow clock");

        // R9: clear request
        @(negedge ref_clk); susp_req = 1'b0;
        @(posedge ref_clk); #1;
        check(suspended == 1'b0, "R9 suspended cleared", suspended, 0);
        check(clk_en == 1'b1, "R9 clk_en restored", clk_en, 1);
        repeat (30) @(negedge ref_clk);
        capture(40);
        check_runs(40, 3, 3, 3, 3, 1'b0, "R9 divided output back");

        // R5: cancel before expiry
        @(negedge ref_clk); susp_req = 1'b1;
        repeat (DLY - 1) @(negedge ref_clk);
        susp_req = 1'b0;
        repeat (5) @(negedge ref_clk);
        check(suspended == 1'b0, "R5 cancel", suspended, 0);
        capture(40);
        check_runs(40, 3, 3, 3, 3, 1'b0, "R5 output after cancel");

        // R11: switch spanning the timer expiry, two divisors
        for (int s = 0; s < 2; s++) begin
            int nv;
            nv = (s == 0) ? 2 : 5;
            cfg_write(word(1'b0, 1'b0, nv));
            repeat (20) @(negedge ref_clk);
            susp_req = 1'b1;
            capture(2 * (DLY + 80));
            check_runs(2 * (DLY + 80), nv + 1, 2 * LH, 0, 0, 1'b1, "R11 switch to slow");
            check(suspended == 1'b1, "R11 suspended reached", suspended, 1);
            @(negedge ref_clk); susp_req = 1'b0;
            capture(120);
            check_runs(120, nv + 1, 2 * LH, 0, 0, 1'b1, "R11 switch back");
        end

        // R10: bus reset
        cfg_write(word(1'b0, 1'b0, 5));
        @(negedge ref_clk); susp_req = 1'b1;
        repeat (DLY + 5) @(negedge ref_clk);
        bus_rst = 1'b1;
        @(negedge ref_clk);
        bus_rst = 1'b0;
        check(suspended == 1'b0, "R10 bus reset clears suspend", suspended, 0);
        check(cfg_rdata == word(1'b0, 1'b0, 5), "R10 cfg kept", cfg_rdata, word(1'b0, 1'b0, 5));
        count_to_susp(cnt);
        check(cnt == DLY, "R10 count restarts", cnt, DLY);
        @(negedge ref_clk); susp_req = 1'b0;

        // R7, R8: parked output, clocks kept running
        cfg_write(word(1'b1, 1'b1, 4));
        repeat (20) @(negedge ref_clk);
        susp_req = 1'b1;
        repeat (DLY + 30) @(negedge ref_clk);
        check(suspended == 1'b1, "R7 suspended", suspended, 1);
        check(clk_en == 1'b1, "R8 clk_en kept", clk_en, 1);
        capture(100);
        hcount = 0;
        for (int i = 0; i < 100; i++) if (halves[i]) hcount++;
        check(hcount == 0, "R7 output low", hcount, 0);
        @(negedge ref_clk); susp_req = 1'b0;
        repeat (30) @(negedge ref_clk);
        capture(60);
        check_runs(60, 5, 5, 5, 5, 1'b0, "R9 resume from parked");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule